// File: doc/BRIEF.md
# I2C Channel Select Controller

This block is an I2C target that owns one control byte and turns its low bits into enable lines for four downstream bus segments. A bus controller addresses it with a 7-bit address and writes a byte to choose which segments are connected. Any mix of segments may be connected at once. The controller can also read the byte back to see the current selection. Because segments should only be joined while every line is idle, new enable bits are staged internally and reach the outputs only when the transfer ends with a STOP.

SCL and SDA are oversampled by the system clock. Each line passes through a synchronizer and a stability filter, and the filtered lines feed an edge and bus-condition detector. A byte-level state machine sits behind the detector. The block never drives SDA high: it only asks for the line to be pulled low, through an output-enable, for acknowledge bits and for zero data bits. A synchronous reset empties the register, deselects every segment and returns the state machine to idle.

Top module: `chsel_ctrl`

## Requirements
- R1: The block acknowledges, by holding SDA low through the ninth SCL pulse, an address byte whose seven upper bits equal binary 1110 followed by strap_i[2], strap_i[1] and strap_i[0]. The last bit of the byte is R/W, where 0 selects a write and 1 selects a read.
- R2: An address byte that does not match is not acknowledged, and the data bytes that follow are neither acknowledged nor stored.
- R3: In a write, every data byte is acknowledged. Bit n of the byte (n = 0..3) enables channel n on chan_en_o[n], and bits 7..4 have no effect.
- R4: When several data bytes are written before the STOP, only the last one decides the channel selection.
- R5: chan_en_o changes only when a STOP is detected. It does not change at the data acknowledge or at a repeated START. A value staged before a repeated START is still applied at the later STOP.
- R6: A read returns the staged byte MSB first, with bits 7..4 equal to zero. The transfer ends when the controller sends a NACK followed by a STOP.
- R7: While rst is high, the staged byte and chan_en_o become zero, sda_oe_o is released and the bus state machine returns to idle.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_CYC system clocks is ignored.
- R9: On the clock after a START or STOP is detected, sda_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 3 | Low three address bits, from board straps |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| chan_en_o | output | 4 | One enable per downstream segment |

## Verification
The bench builds the block with FILT_CYC = 7, so the filter needs 56 ns of stability at 125 MHz. An SCL half period of 40 clocks leaves room for the synchronizer and the filter while a 3-clock SCL spike still falls below the threshold. It also sets strap_i to 101 and later to 010. This puts matching and mismatching addresses within reach of the same vector table: a wrong prefix, a wrong strap bit, and a moved strap. Repeated START, multi-byte writes, read-back with NACK, and a reset in the middle of a write are driven as directed cases.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int unsigned CHSEL_BYTE_W = 8;
  localparam logic [3:0]  CHSEL_PREFIX = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_ACK_R,
    ST_SKIP
  } chsel_state_t;
endpackage

// File: rtl/chsel_filt.sv
module chsel_filt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o <= 1'b1;
      cnt_q <= '0;
    end else if (sync_q[SYNC_STAGES-1] == lvl_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      lvl_o <= sync_q[SYNC_STAGES-1];
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/chsel_cond.sv
module chsel_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_evt = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_evt  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/chsel_fsm.sv
module chsel_fsm
  import chsel_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     strap_i,
  input  logic           sda_f,
  input  logic           scl_rise,
  input  logic           scl_fall,
  input  logic           start_evt,
  input  logic           stop_evt,
  output logic           sda_oe_o,
  output logic [NCH-1:0] chan_en_o,
  output logic [NCH-1:0] shadow_o
);
  localparam int unsigned BW = CHSEL_BYTE_W;
  localparam int unsigned CW = $clog2(BW + 1);

  chsel_state_t      state_q;
  logic [CW-1:0]     bit_q;
  logic [BW-1:0]     rx_q;
  logic [BW-2:0]     tx_q;
  logic              rw_q;
  logic              nack_q;
  logic [NCH-1:0]    shadow_q;
  logic [NCH-1:0]    chan_q;
  logic              oe_q;
  logic [BW-1:0]     tx_load;
  logic              addr_hit;
  logic              byte_done;

  assign tx_load   = BW'(shadow_q);
  assign addr_hit  = (rx_q[BW-1:1] == {CHSEL_PREFIX, strap_i});
  assign byte_done = (bit_q == CW'(BW));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b0;
      shadow_q <= '0;
      chan_q   <= '0;
      oe_q     <= 1'b0;
    end else if (start_evt) begin
      state_q <= ST_ADDR;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_evt) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      chan_q  <= shadow_q;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_q  <= {rx_q[BW-2:0], sda_f};
            bit_q <= bit_q + 1'b1;
          end else if (scl_fall && byte_done) begin
            if (addr_hit) begin
              oe_q    <= 1'b1;
              rw_q    <= rx_q[0];
              state_q <= ST_ACK_A;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            bit_q <= '0;
            if (rw_q) begin
              oe_q    <= ~tx_load[BW-1];
              tx_q    <= tx_load[BW-2:0];
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            rx_q  <= {rx_q[BW-2:0], sda_f};
            bit_q <= bit_q + 1'b1;
          end else if (scl_fall && byte_done) begin
            shadow_q <= rx_q[NCH-1:0];
            oe_q     <= 1'b1;
            state_q  <= ST_ACK_W;
          end
        end
        ST_ACK_W: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_q <= bit_q + 1'b1;
          end else if (scl_fall) begin
            if (byte_done) begin
              oe_q    <= 1'b0;
              state_q <= ST_ACK_R;
            end else begin
              oe_q <= ~tx_q[BW-2];
              tx_q <= {tx_q[BW-3:0], 1'b0};
            end
          end
        end
        ST_ACK_R: begin
          if (scl_rise) begin
            nack_q <= sda_f;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_q <= ST_SKIP;
            end else begin
              bit_q   <= '0;
              oe_q    <= ~tx_load[BW-1];
              tx_q    <= tx_load[BW-2:0];
              state_q <= ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = oe_q;
  assign chan_en_o = chan_q;
  assign shadow_o  = shadow_q;
endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl #(
  parameter int unsigned FILT_CYC    = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NCH         = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     strap_i,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe_o,
  output logic [NCH-1:0] chan_en_o
);
  localparam int unsigned NLINE = 2;

  logic [NLINE-1:0] pin_raw;
  logic [NLINE-1:0] pin_flt;
  logic             scl_rise, scl_fall, start_evt, stop_evt;
  logic [NCH-1:0]   shadow;

  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    chsel_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC)
    ) u_filt (
      .clk  (clk),
      .rst  (rst),
      .pin_i(pin_raw[g]),
      .lvl_o(pin_flt[g])
    );
  end

  chsel_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (pin_flt[0]),
    .sda_f    (pin_flt[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  chsel_fsm #(.NCH(NCH)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .strap_i  (strap_i),
    .sda_f    (pin_flt[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_oe_o (sda_oe_o),
    .chan_en_o(chan_en_o),
    .shadow_o (shadow)
  );
endmodule

// File: rtl/chsel_ctrl_chk.sv
module chsel_ctrl_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           sda_oe_o,
  input logic [NCH-1:0] chan_en_o,
  input logic           start_evt,
  input logic           stop_evt,
  input logic [NCH-1:0] shadow
);
  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (chan_en_o == '0 && !sda_oe_o)); // R7

  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stop_evt |=> $stable(chan_en_o)); // R5

  AST_CHAN_LOAD: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (chan_en_o == $past(shadow))); // R5

  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (start_evt || stop_evt) |=> !sda_oe_o); // R9
endmodule

bind chsel_ctrl chsel_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sda_oe_o (sda_oe_o),
  .chan_en_o(chan_en_o),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .shadow   (shadow)
);

// File: tb/chsel_ctrl_bench.sv
module chsel_ctrl_bench;
  localparam int H = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [3:0] chan;
  logic       sda_bus;
  int         nchk = 0;
  int         nfail = 0;

  assign sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  chsel_ctrl #(.FILT_CYC(7)) u_chsel_ctrl (
    .clk      (clk),
    .rst      (rst),
    .strap_i  (strap),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .chan_en_o(chan)
  );

  // fields: addr[19:13] data[12:5] ack[4] chan[3:0]
  localparam logic [19:0] VEC [6] = '{
    {7'h75, 8'h05, 1'b1, 4'h5},
    {7'h75, 8'hFA, 1'b1, 4'hA},
    {7'h74, 8'h03, 1'b0, 4'hA},
    {7'h65, 8'h0F, 1'b0, 4'hA},
    {7'h75, 8'h00, 1'b1, 4'h0},
    {7'h75, 8'h0F, 1'b1, 4'hF}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H/2);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(H/2);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H/2);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic xfer_byte(input logic [7:0] d, input logic mack, input int glitch_bit,
                           output logic [7:0] rd, output logic slv_ack);
    for (int i = 0; i < 8; i++) begin
      sda_m = d[7-i];
      tick(H/2);
      if (i == glitch_bit) begin
        scl_m = 1'b1; tick(3); scl_m = 1'b0;
      end
      tick(H/2);
      scl_m = 1'b1; tick(H/2);
      rd[7-i] = sda_bus;
      tick(H/2);
      scl_m = 1'b0;
    end
    sda_m = mack;
    tick(H);
    scl_m = 1'b1; tick(H/2);
    slv_ack = ~sda_bus;
    tick(H/2);
    scl_m = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic       ack;
    tick(5);
    rst = 1'b0;
    tick(5);
    chk("R7 reset chan", 8'(chan), 8'h0);
    chk("R7 reset oe", 8'(sda_oe), 8'h0);

    // vector table: R1 R2 R3
    for (int i = 0; i < 6; i++) begin
      logic [19:0] v;
      v = VEC[i];
      bus_start();
      xfer_byte({v[19:13], 1'b0}, 1'b1, -1, rd, ack);
      chk("R1/R2 addr ack", 8'(ack), 8'(v[4]));
      xfer_byte(v[12:5], 1'b1, -1, rd, ack);
      bus_stop();
      tick(20);
      chk("R3 chan after write", 8'(chan), 8'(v[3:0]));
    end

    // R5: pending until STOP
    bus_start();
    xfer_byte(8'hEA, 1'b1, -1, rd, ack);
    xfer_byte(8'h03, 1'b1, -1, rd, ack);
    chk("R3 data ack", 8'(ack), 8'h1);
    tick(20);
    chk("R5 no change before stop", 8'(chan), 8'hF);
    bus_stop();
    tick(20);
    chk("R5 applied at stop", 8'(chan), 8'h3);
    chk("R9 released after stop", 8'(sda_oe), 8'h0);

    // R4: last byte wins
    bus_start();
    xfer_byte(8'hEA, 1'b1, -1, rd, ack);
    xfer_byte(8'h01, 1'b1, -1, rd, ack);
    xfer_byte(8'h02, 1'b1, -1, rd, ack);
    xfer_byte(8'h04, 1'b1, -1, rd, ack);
    bus_stop();
    tick(20);
    chk("R4 last byte kept", 8'(chan), 8'h4);

    // R6: read back
    bus_start();
    xfer_byte(8'hEA, 1'b1, -1, rd, ack);
    xfer_byte(8'hF6, 1'b1, -1, rd, ack);
    bus_stop();
    bus_start();
    xfer_byte(8'hEB, 1'b1, -1, rd, ack);
    chk("R6 read addr ack", 8'(ack), 8'h1);
    xfer_byte(8'hFF, 1'b1, -1, rd, ack);
    chk("R6 read data", rd, 8'h06);
    bus_stop();
    tick(20);
    chk("R6 chan after read", 8'(chan), 8'h6);

    // R5: repeated START does not apply
    bus_start();
    xfer_byte(8'hEA, 1'b1, -1, rd, ack);
    xfer_byte(8'h09, 1'b1, -1, rd, ack);
    bus_rstart();
    xfer_byte(8'hEB, 1'b1, -1, rd, ack);
    xfer_byte(8'hFF, 1'b1, -1, rd, ack);
    chk("R6 read staged", rd, 8'h09);
    chk("R5 held over rstart", 8'(chan), 8'h6);
    bus_stop();
    tick(20);
    chk("R5 applied at final stop", 8'(chan), 8'h9);

    // R8: short SCL spike inside a data byte
    bus_start();
    xfer_byte(8'hEA, 1'b1, -1, rd, ack);
    xfer_byte(8'h05, 1'b1, 2, rd, ack);
    chk("R8 ack despite spike", 8'(ack), 8'h1);
    bus_stop();
    tick(20);
    chk("R8 spike ignored", 8'(chan), 8'h5);

    // R1: moved strap
    strap = 3'b010;
    tick(5);
    bus_start();
    xfer_byte(8'hEA, 1'b1, -1, rd, ack);
    chk("R1 old address rejected", 8'(ack), 8'h0);
    bus_stop();
    bus_start();
    xfer_byte(8'hE4, 1'b1, -1, rd, ack);
    chk("R1 new strap ack", 8'(ack), 8'h1);
    xfer_byte(8'h0C, 1'b1, -1, rd, ack);
    bus_stop();
    tick(20);
    chk("R1 new strap write", 8'(chan), 8'hC);
    strap = 3'b101;
    tick(5);

    // R7: reset in mid write
    bus_start();
    xfer_byte(8'hEA, 1'b1, -1, rd, ack);
    xfer_byte(8'h07, 1'b1, -1, rd, ack);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(2);
    chk("R7 mid reset chan", 8'(chan), 8'h0);
    chk("R7 mid reset oe", 8'(sda_oe), 8'h0);
    bus_stop();
    tick(20);
    chk("R7 staged byte cleared", 8'(chan), 8'h0);
    bus_start();
    xfer_byte(8'hEB, 1'b1, -1, rd, ack);
    xfer_byte(8'hFF, 1'b1, -1, rd, ack);
    bus_stop();
    chk("R7 read after reset", rd, 8'h00);

    finish_run();
  end
endmodule